// File: doc/BRIEF.md
# Extended-Precision Compare Unit

This block compares two 80-bit extended-precision floating-point values and returns the outcome as four condition codes and two exception flags. Operand A is the value at the top of the register stack. Operand B is either a second value or, in test-against-zero mode, an implied +0.0. A one-cycle `in_valid` strobe captures a comparison. The codes and flags are registered on the next clock edge, and a `done` pulse marks the cycle in which they become current. The results then hold until the next strobe.

The unit tells four relations apart: greater, less, equal and unordered. A value is unordered against anything when it is a NaN. Zeros compare equal whatever their sign. The caller selects one of two compare variants, and they differ in one respect only. The ordinary variant raises the invalid-operation flag when a NaN is involved, and the quiet variant does not. The unit also drives three helper outputs, so that ordinary unsigned branch conditions can test the result as CPU carry, parity and zero flags.

Top module: `xp_compare_unit`

## Requirements
- R1: `done` is high in the cycle after each cycle in which `in_valid` is high, and low after every cycle in which `in_valid` is low.
- R2: When A is greater than B, the codes {cc3,cc2,cc0} are 000.
- R3: When A is less than B, the codes {cc3,cc2,cc0} are 001.
- R4: When A equals B, the codes {cc3,cc2,cc0} are 100. +0.0 and -0.0 count as equal.
- R5: When either operand is a NaN, the codes {cc3,cc2,cc0} are 111 (unordered). A NaN has an exponent field of all ones and a nonzero fraction in bits 62:0. Bit 79 is the sign, bits 78:64 the exponent and bits 63:0 the significand.
- R6: `cc1` is 0 after every comparison.
- R7: With `unord_mode` = 0, `flag_invalid` is 1 exactly when either operand is a NaN.
- R8: With `unord_mode` = 1, `flag_invalid` is 0 for every operand pair, including NaNs.
- R9: `flag_denorm` is 1 exactly when either compared operand has a zero exponent field and a nonzero significand.
- R10: With `zero_test` = 1, the value on `op_b` has no effect, and A is compared with +0.0.
- R11: Ordering looks at the sign, then the exponent, then the significand. Any positive value is greater than any negative value, and for two negative values the larger magnitude is the lesser value.
- R12: `cpu_carry` equals `cc0`, `cpu_parity` equals `cc2` and `cpu_zero` equals `cc3`. No CPU flag carries `cc1`.
- R13: While `in_valid` is low, the codes and flags keep their values whatever the operand inputs do.
- R14: After reset, every code, flag and helper output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Capture strobe for one comparison |
| op_a | input | 80 | Operand A (top of stack) |
| op_b | input | 80 | Operand B |
| unord_mode | input | 1 | 1: quiet variant, NaN raises no invalid flag |
| zero_test | input | 1 | 1: compare A against +0.0 |
| cc3 | output | 1 | Condition code 3 (equal / unordered) |
| cc2 | output | 1 | Condition code 2 (unordered) |
| cc1 | output | 1 | Condition code 1, cleared by a compare |
| cc0 | output | 1 | Condition code 0 (less / unordered) |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_denorm | output | 1 | Denormal-operand flag |
| done | output | 1 | One-cycle result strobe |
| cpu_carry | output | 1 | Carry-flag view of cc0 |
| cpu_parity | output | 1 | Parity-flag view of cc2 |
| cpu_zero | output | 1 | Zero-flag view of cc3 |

## Verification
The comparison is driven in several ways, and each one separates a different part of the decision:
- Positive pairs that differ only in the exponent, or only in the significand, show that the magnitude is ordered field by field.
- Negative pairs, and pairs of mixed sign, show that the sign is applied and that the magnitude result is inverted for two negative values.
- Signed zeros, infinity against a finite value, and denormals against zero probe the edges of the encoding.
- NaNs on either side, driven under both compare variants, separate the unordered code from the invalid flag.
- Zero-test strobes carry a NaN on `op_b`, which shows that B is really replaced.
- Back-to-back strobes and an idle stretch with changing operands check that the result appears with the right latency and then holds.

// File: rtl/xp_cmp_pkg.sv
// Package: shared types and the code encoding for the extended-precision compare unit.
// Assumes the caller derives the operand field widths from its own parameters.
package xp_cmp_pkg;

    // Outcome of one comparison
    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    // Class bits of one operand
    typedef struct packed {
        logic nan;
        logic denorm;
        logic zero;
    } xp_class_t;

    // Map a relation onto the codes {c3, c2, c0}
    function automatic logic [2:0] rel_to_codes(rel_e r);
        case (r)
            REL_GT:  return 3'b000;
            REL_LT:  return 3'b001;
            REL_EQ:  return 3'b100;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/xp_classify.sv
// Module: xp_classify
// Sorts one operand into NaN, denormal or zero, looking only at its exponent
// and significand fields. Assumes the significand carries an explicit integer
// bit in its top position. That bit is ignored for the NaN test.
module xp_classify
    import xp_cmp_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64
) (
    input  logic [EXP_W-1:0] exp_f,
    input  logic [SIG_W-1:0] sig_f,
    output xp_class_t        cls
);

    localparam int FRAC_W = SIG_W - 1;

    logic exp_max;
    logic exp_min;
    logic frac_nz;
    logic sig_nz;

    // Detect the field patterns
    always_comb begin
        exp_max = &exp_f;
        exp_min = ~|exp_f;
        frac_nz = |sig_f[FRAC_W-1:0];
        sig_nz  = |sig_f;
    end

    // Build the class bits
    always_comb begin
        cls.nan    = exp_max & frac_nz;
        cls.denorm = exp_min & sig_nz;
        cls.zero   = exp_min & ~sig_nz;
    end

endmodule

// File: rtl/xp_order.sv
// Module: xp_order
// Orders two values that are not NaN. The sign is checked first, then the
// magnitude, which is the exponent followed by the significand. Two zeros
// compare equal whatever their signs.
module xp_order
    import xp_cmp_pkg::*;
#(
    parameter int MAG_W = 79
) (
    input  logic             sign_a,
    input  logic             sign_b,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    input  logic             zero_a,
    input  logic             zero_b,
    output rel_e             rel
);

    logic mag_eq;
    logic mag_gt;

    // Unsigned magnitude compare
    always_comb begin
        mag_eq = (mag_a == mag_b);
        mag_gt = (mag_a > mag_b);
    end

    // Combine sign and magnitude into a relation
    always_comb begin
        if (zero_a && zero_b) begin
            rel = REL_EQ;
        end else if (sign_a != sign_b) begin
            rel = sign_a ? REL_LT : REL_GT;
        end else if (mag_eq) begin
            rel = REL_EQ;
        end else begin
            rel = (mag_gt ^ sign_a) ? REL_GT : REL_LT;
        end
    end

endmodule

// File: rtl/xp_compare_unit.sv
// Module: xp_compare_unit (top)
// Compares two extended-precision operands and registers the condition codes
// and the exception flags one cycle after in_valid. The results hold until the
// next strobe. Assumes the operand layout is sign, exponent, significand, from
// most to least significant bit.
module xp_compare_unit
    import xp_cmp_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    localparam int MAG_W = EXP_W + SIG_W,
    localparam int OP_W  = 1 + MAG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    input  logic            unord_mode,
    input  logic            zero_test,
    output logic            cc3,
    output logic            cc2,
    output logic            cc1,
    output logic            cc0,
    output logic            flag_invalid,
    output logic            flag_denorm,
    output logic            done,
    output logic            cpu_carry,
    output logic            cpu_parity,
    output logic            cpu_zero
);

    localparam int N_OPS = 2;

    logic [OP_W-1:0] opnd [N_OPS];
    xp_class_t       cls  [N_OPS];
    rel_e            rel_ord;
    rel_e            rel_nx;
    logic            any_nan;
    logic            any_den;
    logic [2:0]      codes_nx;

    // Select the operands, replacing B with +0.0 in zero-test mode
    always_comb begin
        opnd[0] = op_a;
        opnd[1] = zero_test ? '0 : op_b;
    end

    // One classifier per operand
    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        xp_classify #(
            .EXP_W(EXP_W),
            .SIG_W(SIG_W)
        ) u_cls (
            .exp_f(opnd[g][OP_W-2:SIG_W]),
            .sig_f(opnd[g][SIG_W-1:0]),
            .cls  (cls[g])
        );
    end

    xp_order #(
        .MAG_W(MAG_W)
    ) u_order (
        .sign_a(opnd[0][OP_W-1]),
        .sign_b(opnd[1][OP_W-1]),
        .mag_a (opnd[0][MAG_W-1:0]),
        .mag_b (opnd[1][MAG_W-1:0]),
        .zero_a(cls[0].zero),
        .zero_b(cls[1].zero),
        .rel   (rel_ord)
    );

    // Merge the NaN and denormal detection with the ordering
    always_comb begin
        any_nan  = cls[0].nan | cls[1].nan;
        any_den  = cls[0].denorm | cls[1].denorm;
        rel_nx   = any_nan ? REL_UN : rel_ord;
        codes_nx = rel_to_codes(rel_nx);
    end

    // Capture the results on a strobe and raise done for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc3          <= 1'b0;
            cc2          <= 1'b0;
            cc1          <= 1'b0;
            cc0          <= 1'b0;
            flag_invalid <= 1'b0;
            flag_denorm  <= 1'b0;
            done         <= 1'b0;
        end else begin
            done <= in_valid;
            if (in_valid) begin
                cc3          <= codes_nx[2];
                cc2          <= codes_nx[1];
                cc0          <= codes_nx[0];
                cc1          <= 1'b0;
                flag_invalid <= any_nan & ~unord_mode;
                flag_denorm  <= any_den;
            end
        end
    end

    // Present the codes as CPU branch flags
    always_comb begin
        cpu_carry  = cc0;
        cpu_parity = cc2;
        cpu_zero   = cc3;
    end

endmodule

// File: rtl/xp_compare_checker.sv
// Module: xp_compare_checker
// Temporal checks on the ports of xp_compare_unit, attached with bind.
module xp_compare_checker #(
    parameter int OP_W = 80
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [OP_W-1:0] op_a,
    input logic            unord_mode,
    input logic            zero_test,
    input logic            cc3,
    input logic            cc2,
    input logic            cc0,
    input logic            flag_invalid,
    input logic            flag_denorm,
    input logic            done
);

    // R1: done follows a strobe
    assert_done_after_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    // R1: no done without a strobe
    assert_no_stray_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);

    // R5: an unordered code always has all three bits set
    assert_unordered_pattern_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cc2 |-> (cc3 && cc0));

    // R7: the invalid flag appears only with an unordered result
    assert_invalid_needs_nan_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |-> cc2);

    // R8: the quiet variant never raises invalid
    assert_quiet_no_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && unord_mode) |=> !flag_invalid);

    // R10: a zero A in zero-test mode reports equal, whatever its sign
    assert_zero_test_equal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_test && (op_a[OP_W-2:0] == '0)) |=> (cc3 && !cc2 && !cc0));

    // R13: the results hold between strobes
    assert_hold_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable({cc3, cc2, cc0, flag_invalid, flag_denorm}));

endmodule

bind xp_compare_unit xp_compare_checker #(.OP_W(OP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_a        (op_a),
    .unord_mode  (unord_mode),
    .zero_test   (zero_test),
    .cc3         (cc3),
    .cc2         (cc2),
    .cc0         (cc0),
    .flag_invalid(flag_invalid),
    .flag_denorm (flag_denorm),
    .done        (done)
);

// File: tb/xp_compare_unit_bench.sv
// Scoreboard bench: the driver queues expected results from a reference model,
// and the monitor pops them when done is seen.
module xp_compare_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [79:0] op_a = '0;
    logic [79:0] op_b = '0;
    logic        unord_mode = 1'b0;
    logic        zero_test = 1'b0;
    logic        cc3, cc2, cc1, cc0, flag_invalid, flag_denorm, done;
    logic        cpu_carry, cpu_parity, cpu_zero;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    typedef struct {
        logic [2:0] codes;
        logic       inv;
        logic       den;
        int         due;
        string      tag;
    } exp_t;

    exp_t sb[$];
    exp_t last_exp;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    xp_compare_unit u_xp_compare_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .unord_mode(unord_mode), .zero_test(zero_test),
        .cc3(cc3), .cc2(cc2), .cc1(cc1), .cc0(cc0),
        .flag_invalid(flag_invalid), .flag_denorm(flag_denorm), .done(done),
        .cpu_carry(cpu_carry), .cpu_parity(cpu_parity), .cpu_zero(cpu_zero)
    );

    function automatic logic [79:0] mk(logic s, logic [14:0] e, logic [63:0] m);
        return {s, e, m};
    endfunction

    function automatic bit is_nan(logic [79:0] v);
        return (v[78:64] == 15'h7fff) && (v[62:0] != 0);
    endfunction

    function automatic bit is_den(logic [79:0] v);
        return (v[78:64] == 0) && (v[63:0] != 0);
    endfunction

    // Monotone key: positives above negatives, negatives mirrored
    function automatic logic [79:0] okey(logic [79:0] v);
        return v[79] ? {1'b0, ~v[78:0]} : {1'b1, v[78:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Driver: one strobe, expected result pushed to the scoreboard
    task automatic apply(logic [79:0] a, logic [79:0] b, logic um, logic zt, string tag);
        exp_t e;
        logic [79:0] bb;
        @(negedge clk);
        bb = zt ? 80'd0 : b;
        if (is_nan(a) || is_nan(bb))             e.codes = 3'b111;
        else if (a[78:0] == 0 && bb[78:0] == 0)  e.codes = 3'b100;
        else if (okey(a) > okey(bb))             e.codes = 3'b000;
        else if (okey(a) < okey(bb))             e.codes = 3'b001;
        else                                     e.codes = 3'b100;
        e.inv = (is_nan(a) || is_nan(bb)) && !um;
        e.den = is_den(a) || is_den(bb);
        e.due = cyc + 1;
        e.tag = tag;
        sb.push_back(e);
        op_a = a; op_b = b; unord_mode = um; zero_test = zt; in_valid = 1'b1;
    endtask

    // Monitor: compare each result as done appears
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check("R1 done without strobe", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                last_exp = e;
                check({"R1 latency ", e.tag}, cyc, e.due);
                check(e.tag, {cc3, cc2, cc0}, e.codes);
                check({"R7/R8 invalid ", e.tag}, flag_invalid, e.inv);
                check({"R9 denorm ", e.tag}, flag_denorm, e.den);
                check({"R6 cc1 ", e.tag}, cc1, 0);
                check({"R12 cpu flags ", e.tag}, {cpu_zero, cpu_parity, cpu_carry}, {cc3, cc2, cc0});
            end
        end
    end

    // Watchdog
    initial begin
        #1000000;
        check("watchdog expired", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [79:0] one, two, ninf, qnan, dnm, pz, nz;
        one  = mk(0, 15'd16383, 64'h8000_0000_0000_0000);
        two  = mk(0, 15'd16384, 64'h8000_0000_0000_0000);
        ninf = mk(0, 15'h7fff, 64'h8000_0000_0000_0000);
        qnan = mk(0, 15'h7fff, 64'hC000_0000_0000_0000);
        dnm  = mk(0, 15'd0, 64'h0000_0000_0000_0001);
        pz   = 80'd0;
        nz   = mk(1, 15'd0, 64'd0);

        repeat (3) @(negedge clk);
        // R14: reset state
        check("R14 reset outputs",
              {cc3, cc2, cc1, cc0, flag_invalid, flag_denorm, done, cpu_carry, cpu_parity, cpu_zero}, 0);
        rst_n = 1'b1;

        apply(two, one, 0, 0, "R2 exp greater");
        apply(one, two, 0, 0, "R3 exp less");
        apply(one, one, 0, 0, "R4 equal");
        apply(pz, nz, 0, 0, "R4 signed zeros");
        apply(mk(0, 15'd16383, 64'hC000_0000_0000_0000), one, 0, 0, "R2 significand greater");
        apply(two | 80'h8000_0000_0000_0000_0000, one | 80'h8000_0000_0000_0000_0000, 0, 0, "R11 neg less");
        apply(one | 80'h8000_0000_0000_0000_0000, two | 80'h8000_0000_0000_0000_0000, 0, 0, "R11 neg greater");
        apply(one | 80'h8000_0000_0000_0000_0000, one, 0, 0, "R11 mixed sign");
        apply(ninf, two, 0, 0, "R2 infinity");
        apply(qnan, one, 0, 0, "R5 R7 nan normal mode");
        apply(one, qnan, 1, 0, "R5 R8 nan quiet mode");
        apply(qnan, qnan, 1, 0, "R5 R8 two nans quiet");
        apply(dnm, pz, 0, 0, "R9 denormal vs zero");
        apply(dnm | 80'h8000_0000_0000_0000_0000, qnan, 0, 1, "R10 R9 neg denormal zero test");
        apply(nz, qnan, 0, 1, "R10 negative zero test");
        apply(two, qnan, 0, 1, "R10 op_b ignored");
        apply(one | 80'h8000_0000_0000_0000_0000, two, 1, 1, "R10 negative vs zero");

        @(negedge clk);
        in_valid = 1'b0;
        op_a = qnan; op_b = dnm; zero_test = 1'b0; unord_mode = 1'b0;
        repeat (2) @(negedge clk);
        // R13: results unchanged while idle with new operands
        repeat (3) begin
            check("R13 hold codes", {cc3, cc2, cc0}, last_exp.codes);
            check("R13 hold flags", {flag_invalid, flag_denorm}, {last_exp.inv, last_exp.den});
            check("R1 done idle", done, 0);
            @(negedge clk);
        end
        check("R1 all results seen", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule